// File: doc/BRIEF.md
# Prescaled Match Counter

This block is a counter timer that runs from a slow source clock. A power-of-two prescaler produces a one-cycle step strobe. The prescaler is set by a 4-bit logarithmic code: code N gives one step every 2^N source cycles. The counter advances only on those strobes, and only while the block is enabled.

A 2-bit mode field sets how the counter behaves:
- Mode 0 runs a full 32-bit count.
- Mode 1 runs a 16-bit count in the low half.
- Modes 2 and 3 hold the count. Mode 2 is a calendar mode that is not implemented here; mode 3 is reserved.

A compare value is checked on every step. When the count equals it, a one-cycle match pulse is raised. In mode 0 the counter can also be made to restart from zero on a match. The block is used as a periodic tick source or as a free-running timebase.

Top module: `prescaled_match_counter`

## Requirements
- R1: While reset is low, and after its release until the first step, count is 0 and match_pulse is 0.
- R2: With div_sel = N, where N is in 0..10, and run high, the counter steps once every 2^N clock cycles. The first step lands on the 2^N-th rising edge after run is seen high, so with N = 0 the count rises on every edge.
- R3: With div_sel in 0xB..0xF, no step occurs: count holds and match_pulse stays 0.
- R4: While run is low, count holds. When run rises again, the prescaler restarts from zero.
- R5: In mode 0 (op_mode = 0), each step adds 1 to the full 32-bit count, and the compare uses all 32 bits of cmp0.
- R6: In mode 1 (op_mode = 1), each step adds 1 to the low 16 bits, wraps 0xFFFF to 0, and forces the upper 16 bits to zero. The compare uses only cmp0[15:0].
- R7: In mode 2 and mode 3, count holds, no clearing takes place, and match_pulse stays 0.
- R8: In mode 0 with clr_on_match = 1, a step taken while count equals cmp0 loads 0 instead of cmp0 + 1.
- R9: In mode 0 with clr_on_match = 0, a step taken while count equals cmp0 loads cmp0 + 1.
- R10: In mode 1, clr_on_match has no effect: a matching step loads the value + 1.
- R11: match_pulse is high for exactly the one cycle that follows a step taken in mode 0 or 1 while the count matched cmp0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Enables the prescaler and counter |
| div_sel | input | 4 | Prescaler code N, dividing by 2^N; codes 0xB..0xF are reserved |
| op_mode | input | 2 | 0: 32-bit, 1: 16-bit, 2: calendar (holds), 3: reserved (holds) |
| clr_on_match | input | 1 | Clear the count on a compare match, in mode 0 only |
| cmp0 | input | 32 | Compare value |
| count | output | 32 | Current count |
| match_pulse | output | 1 | One-cycle pulse after a matching step |

## Verification
The step strobe is combinational from the prescaler register, so it is high during the cycle in which the divider shows all ones in its low N bits. Count takes its new value on that cycle's rising edge, and match_pulse rises on the same edge. Both results are therefore due on the 2^N-th edge after run goes high, and every 2^N edges after that.

The bench drives inputs and samples outputs only on falling edges. It counts falling edges from each stimulus, so every check lands an exact number of rising edges after the change. Each divider check samples one edge before a step is due and again on the edge where it is due, so a step that comes early or late is reported.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   typedef enum logic [1:0] {
      MODE_C32 = 2'd0,
      MODE_C16 = 2'd1,
      MODE_CAL = 2'd2,
      MODE_RSV = 2'd3
   } pmc_mode_e;
endpackage

// File: rtl/pmc_prescaler.sv
module pmc_prescaler #(
   parameter int CODE_W   = 4,
   parameter int MAX_CODE = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [CODE_W-1:0] div_sel,
   output logic              strobe
);
   localparam int DIV_W = MAX_CODE;

   if (MAX_CODE < 1) begin : g_bad_min
      $error("pmc_prescaler: MAX_CODE must be at least 1");
   end
   if (MAX_CODE >= (1 << CODE_W)) begin : g_bad_code
      $error("pmc_prescaler: MAX_CODE does not fit in CODE_W bits");
   end

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;
   logic             code_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    div_q <= '0;
      else if (!run) div_q <= '0;
      else           div_q <= div_q + 1'b1;
   end

   for (genvar i = 0; i < DIV_W; i++) begin : g_mask
      assign mask[i] = (div_sel > CODE_W'(i));
   end

   assign code_ok = (div_sel <= CODE_W'(MAX_CODE));
   assign strobe  = run && code_ok && ((div_q & mask) == mask);
endmodule

// File: rtl/pmc_match.sv
module pmc_match
   import pmc_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int HALF_W = 16
) (
   input  logic [CNT_W-1:0] count_q,
   input  logic [CNT_W-1:0] cmp,
   input  pmc_mode_e        mode,
   output logic             hit
);
   logic hit_full;
   logic hit_half;

   assign hit_full = (count_q == cmp);
   assign hit_half = (count_q[HALF_W-1:0] == cmp[HALF_W-1:0]);
   assign hit      = (mode == MODE_C16) ? hit_half : hit_full;
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter
   import pmc_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int HALF_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  pmc_mode_e        mode,
   input  logic             clr_en,
   input  logic             hit,
   output logic [CNT_W-1:0] count_q,
   output logic             pulse_q
);
   localparam int UP_W = CNT_W - HALF_W;

   if (HALF_W >= CNT_W || HALF_W < 1) begin : g_bad_half
      $error("pmc_counter: HALF_W must be between 1 and CNT_W-1");
   end

   logic [CNT_W-1:0]  nxt;
   logic [HALF_W-1:0] low_inc;
   logic              pulse_d;

   assign low_inc = count_q[HALF_W-1:0] + 1'b1;

   always_comb begin
      nxt     = count_q;
      pulse_d = 1'b0;
      if (strobe) begin
         unique case (mode)
            MODE_C32: begin
               nxt     = (hit && clr_en) ? '0 : count_q + 1'b1;
               pulse_d = hit;
            end
            MODE_C16: begin
               nxt     = {{UP_W{1'b0}}, low_inc};
               pulse_d = hit;
            end
            default: nxt = count_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         pulse_q <= 1'b0;
      end else begin
         count_q <= nxt;
         pulse_q <= pulse_d;
      end
   end

   // R3 R4: without a step the count must not move
   a_r4_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> $stable(count_q));
   // R5 R9: a plain mode 0 step adds one
   a_r5_step_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && mode == MODE_C32 && !(hit && clr_en))
      |=> count_q == $past(count_q) + {{(CNT_W-1){1'b0}}, 1'b1});
   // R6: 16-bit mode keeps upper half at zero
   a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && mode == MODE_C16) |=> count_q[CNT_W-1:HALF_W] == '0);
   // R7: calendar and reserved modes hold and stay silent
   a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && (mode == MODE_CAL || mode == MODE_RSV)) |=> ($stable(count_q) && !pulse_q));
   // R8: clear on a matching step in mode 0
   a_r8_clear_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && mode == MODE_C32 && clr_en && hit) |=> count_q == '0);
   // R11: a pulse always follows a step
   a_r11_pulse_after_step: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> $past(strobe));
endmodule

// File: rtl/prescaled_match_counter.sv
module prescaled_match_counter
   import pmc_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int HALF_W   = 16,
   parameter int CODE_W   = 4,
   parameter int MAX_CODE = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [CODE_W-1:0] div_sel,
   input  logic [1:0]        op_mode,
   input  logic              clr_on_match,
   input  logic [CNT_W-1:0]  cmp0,
   output logic [CNT_W-1:0]  count,
   output logic              match_pulse
);
   pmc_mode_e mode;
   logic      strobe;
   logic      hit;
   logic      clr_en;

   assign mode   = pmc_mode_e'(op_mode);
   assign clr_en = clr_on_match && (mode == MODE_C32 || mode == MODE_CAL);

   pmc_prescaler #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .div_sel(div_sel), .strobe(strobe));

   pmc_match #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_match (
      .count_q(count), .cmp(cmp0), .mode(mode), .hit(hit));

   pmc_counter #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .strobe(strobe), .mode(mode), .clr_en(clr_en),
      .hit(hit), .count_q(count), .pulse_q(match_pulse));

   // R1: reset leaves the outputs clear
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (!rst_n || (count == '0 && !match_pulse)));
endmodule

// File: tb/tb_prescaled_match_counter.sv
module tb_prescaled_match_counter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic [3:0]  div_sel = 4'd0;
   logic [1:0]  op_mode = 2'd0;
   logic        clr_on_match = 1'b0;
   logic [31:0] cmp0 = 32'd0;
   logic [31:0] count;
   logic        match_pulse;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   prescaled_match_counter dut (
      .clk(clk), .rst_n(rst_n), .run(run), .div_sel(div_sel), .op_mode(op_mode),
      .clr_on_match(clr_on_match), .cmp0(cmp0), .count(count), .match_pulse(match_pulse));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic restart(input logic [3:0] d, input logic [1:0] m, input logic c,
                          input logic [31:0] k);
      @(negedge clk);
      rst_n = 1'b0; run = 1'b0;
      div_sel = d; op_mode = m; clr_on_match = c; cmp0 = k;
      step(2);
      rst_n = 1'b1; run = 1'b1;
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst_n = 1'b0; run = 1'b1;
      step(3);
      check("R1 count in reset", count, 32'd0);
      check("R1 pulse in reset", {31'd0, match_pulse}, 32'd0);
      rst_n = 1'b1; run = 1'b0;
      step(2);
      check("R1 count after release", count, 32'd0);
   endtask

   task automatic t_div1;
      restart(4'd0, 2'd0, 1'b0, 32'hFFFF_0000);
      step(7);
      check("R2 div1 count", count, 32'd7);
      check("R5 mode0 step", count, 32'd7);
   endtask

   task automatic t_div4;
      restart(4'd2, 2'd0, 1'b0, 32'hFFFF_0000);
      step(3);
      check("R2 div4 before first", count, 32'd0);
      step(1);
      check("R2 div4 first step", count, 32'd1);
      step(3);
      check("R2 div4 mid period", count, 32'd1);
      step(1);
      check("R2 div4 second step", count, 32'd2);
   endtask

   task automatic t_div1024;
      restart(4'hA, 2'd0, 1'b0, 32'hFFFF_0000);
      step(1023);
      check("R2 div1024 before first", count, 32'd0);
      step(1);
      check("R2 div1024 first step", count, 32'd1);
   endtask

   task automatic t_reserved;
      for (int c = 11; c < 16; c++) begin
         restart(4'(c), 2'd0, 1'b0, 32'd0);
         for (int i = 0; i < 40; i++) begin
            step(1);
            if (match_pulse) check("R3 reserved pulse", 32'd1, 32'd0);
         end
         check("R3 reserved code holds", count, 32'd0);
      end
   endtask

   task automatic t_disable;
      restart(4'd2, 2'd0, 1'b0, 32'hFFFF_0000);
      step(6);
      check("R4 before disable", count, 32'd1);
      run = 1'b0;
      step(9);
      check("R4 disabled hold", count, 32'd1);
      run = 1'b1;
      step(3);
      check("R4 prescaler restarted", count, 32'd1);
      step(1);
      check("R4 first step after rerun", count, 32'd2);
   endtask

   task automatic t_m0_clear;
      restart(4'd0, 2'd0, 1'b1, 32'd5);
      step(5);
      check("R8 reach compare", count, 32'd5);
      check("R11 no early pulse", {31'd0, match_pulse}, 32'd0);
      step(1);
      check("R8 cleared", count, 32'd0);
      check("R11 pulse on clear", {31'd0, match_pulse}, 32'd1);
      step(1);
      check("R8 counts after clear", count, 32'd1);
      check("R11 pulse one cycle", {31'd0, match_pulse}, 32'd0);
   endtask

   task automatic t_m0_noclear;
      restart(4'd0, 2'd0, 1'b0, 32'd5);
      step(6);
      check("R9 passes through", count, 32'd6);
      check("R11 pulse no clear", {31'd0, match_pulse}, 32'd1);
      step(1);
      check("R11 pulse dropped", {31'd0, match_pulse}, 32'd0);
   endtask

   task automatic t_m0_fullcmp;
      restart(4'd0, 2'd0, 1'b1, 32'h0001_0003);
      step(4);
      check("R5 upper bits compared", count, 32'd4);
      check("R5 no pulse on half match", {31'd0, match_pulse}, 32'd0);
   endtask

   task automatic t_m1_ignore;
      restart(4'd0, 2'd1, 1'b1, 32'hABCD_0003);
      step(4);
      check("R10 clear ignored in mode1", count, 32'd4);
      check("R6 low half compare pulse", {31'd0, match_pulse}, 32'd1);
   endtask

   task automatic t_m1_wrap;
      restart(4'd0, 2'd1, 1'b0, 32'h0000_1234);
      step(65535);
      check("R6 top of 16-bit range", count, 32'h0000_FFFF);
      step(1);
      check("R6 wraps to zero", count, 32'd0);
   endtask

   task automatic t_cal_hold;
      restart(4'd0, 2'd0, 1'b0, 32'hFFFF_0000);
      step(5);
      check("R7 lead-in count", count, 32'd5);
      op_mode = 2'd2; cmp0 = 32'd5; clr_on_match = 1'b1;
      for (int i = 0; i < 10; i++) begin
         step(1);
         if (match_pulse) check("R7 calendar pulse", 32'd1, 32'd0);
      end
      check("R7 calendar holds", count, 32'd5);
      op_mode = 2'd3;
      step(10);
      check("R7 reserved mode holds", count, 32'd5);
      check("R7 reserved mode no pulse", {31'd0, match_pulse}, 32'd0);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_div1();
      t_div4();
      t_div1024();
      t_reserved();
      t_disable();
      t_m0_clear();
      t_m0_noclear();
      t_m0_fullcmp();
      t_m1_ignore();
      t_m1_wrap();
      t_cal_hold();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule